// File: doc/BRIEF.md
# Battery-Monitor Two-Wire Register Slave

This block is a two-wire serial slave that runs from a fast system clock, oversampling the bus lines. It gives a host controller byte access to a small register map. The map holds a status/configuration byte, four read-only 16-bit values supplied by the measurement logic (temperature, voltage, current and the charge accumulator), and two signed 8-bit bias values. The measurement values come in on input ports. The accumulator is held outside this block, so the block only reads it and reports writes to it.

The host sends a START, the 7-bit device address and a direction bit, then a one-byte register pointer. After that it either writes data bytes or issues a repeated START and reads data bytes. The pointer advances by one after every byte in both directions and stops one past FFh. Reading the high byte of a 16-bit value freezes its low byte until the command ends, so the two halves always belong together. Every write that lands on a writable address also leaves the block as a one-cycle strobe with the address and data, so neighbouring logic can react to it, for example by clearing the accumulator.

The line drivers are open-drain. The slave only ever pulls SDA low through `sda_oe`, and the general-purpose pin is handled the same way through `gpio_oe`.

Top module: `bmon_i2c_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_oe`=0) and drives the general-purpose pin low (`gpio_oe`=1). Both bias outputs and both configuration outputs are 0, and the status byte reads C0h while the pin is low.
- R2: The slave answers with ACK only to the address {`DEV_ADDR_HI`, status[2:0]} (default 1001000b). Any other address gets no ACK, and the slave ignores the rest of that transaction.
- R3: Writing status bits 2:0 changes the low three bits of the device address. The new address applies from the next START. The old address then gets no ACK.
- R4: In a write, the byte after the device address loads the pointer. Each data byte is ACKed and stored at the pointer, and the pointer then advances. The offset bias lives at 61h and the accumulation bias at 62h.
- R5: In a read, the slave returns bytes MSB first, starting at the pointer set by an earlier write portion, from addresses that rise by one per byte. A master NACK ends the slave's driving.
- R6: The slave ignores writes to the read-only addresses 0Ah–0Fh and to reserved addresses, and raises no strobe for them. Reserved addresses read 00h. The value pairs sit at 0Ah (temperature), 0Ch (voltage), 0Eh (current) and 10h (accumulator), with the high byte at the even address.
- R7: Once the pointer passes FFh, reads return FFh and writes are dropped. The pointer does not wrap to 00h.
- R8: A data byte cut short by a STOP before its eighth bit and ACK is not committed.
- R9: Reading the high byte of a pair latches its low byte. Within the same command, the odd address then returns the latched value even if the input has changed. A new START or a STOP ends the latch.
- R10: Status bit 7 reads 1. Bit 6 is the power-on flag: reset sets it and writes can only clear it. Bit 5 is `cfg_sleep_en` and bit 4 is `cfg_neg_blank`. Writing 0 to bit 3 drives the general-purpose pin low, writing 1 releases it, and reading bit 3 returns the pin level.
- R11: A committed write to 01h, 10h, 11h, 61h or 62h raises `wr_stb` for exactly one cycle, with `wr_addr` and `wr_data`. The accumulator bytes are not stored and still read from `acc_word`.
- R12: `sda_oe` changes only while SCL is low. The slave never drives SDA high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| gpio_i | input | 1 | General-purpose pin level |
| gpio_oe | output | 1 | 1 pulls the general-purpose pin low |
| temp_word | input | 16 | Temperature value |
| volt_word | input | 16 | Voltage value |
| curr_word | input | 16 | Current value |
| acc_word | input | 16 | Accumulator value |
| wr_stb | output | 1 | One-cycle strobe for a committed write |
| wr_addr | output | 8 | Address of the strobed write |
| wr_data | output | 8 | Data of the strobed write |
| cfg_sleep_en | output | 1 | Sleep-enable configuration bit |
| cfg_neg_blank | output | 1 | Negative-blanking enable bit |
| ofs_bias | output | 8 | Offset bias register |
| acc_bias | output | 8 | Accumulation bias register |

## Verification
The bench sets `SYNC_STAGES` to 3, so every SDA change by the slave arrives four system cycles after an SCL fall. With a bus quarter-bit of eight cycles, that latency still lands inside the SCL low phase, which is the case R12 checks. The device-address prefix and the reset value of the low address bits stay at their defaults. The default address 48h must therefore be ACKed, and moving the low bits to 3 (address 4Bh) brings the address-change path within reach. The measurement inputs hold distinct byte patterns, so a swapped byte, a wrong pair or a stale latch shows up as a wrong value.

// File: rtl/bmon_pkg.sv
`timescale 1ns/1ps
package bmon_pkg;

    localparam int MAP_AW = 8;

    localparam logic [MAP_AW-1:0] ADR_STAT  = 8'h01;
    localparam logic [MAP_AW-1:0] ADR_TEMP  = 8'h0A;
    localparam logic [MAP_AW-1:0] ADR_VOLT  = 8'h0C;
    localparam logic [MAP_AW-1:0] ADR_CURR  = 8'h0E;
    localparam logic [MAP_AW-1:0] ADR_ACC   = 8'h10;
    localparam logic [MAP_AW-1:0] ADR_ACC_L = ADR_ACC | 8'h01;
    localparam logic [MAP_AW-1:0] ADR_OFS   = 8'h61;
    localparam logic [MAP_AW-1:0] ADR_ABIAS = 8'h62;

    // pair tags: address with the byte-select bit dropped
    localparam logic [MAP_AW-2:0] TAG_TEMP = ADR_TEMP[MAP_AW-1:1];
    localparam logic [MAP_AW-2:0] TAG_VOLT = ADR_VOLT[MAP_AW-1:1];
    localparam logic [MAP_AW-2:0] TAG_CURR = ADR_CURR[MAP_AW-1:1];
    localparam logic [MAP_AW-2:0] TAG_ACC  = ADR_ACC[MAP_AW-1:1];

    typedef enum logic [3:0] {
        L_IDLE, L_DEV, L_DEV_ACK, L_PTR, L_PTR_ACK,
        L_WR, L_WR_ACK, L_RD, L_RD_ACK, L_WAIT
    } link_st_e;

    typedef struct packed {
        link_st_e          st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [MAP_AW:0]   ptr;
        logic              rw;
        logic              nack;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
        logic              wr_en;
        logic [MAP_AW-1:0] wa;
        logic [7:0]        wd;
    } link_q_t;

    typedef struct packed {
        logic              por;
        logic              sleep_en;
        logic              nblank;
        logic              pin_rel;
        logic [2:0]        alo;
        logic [7:0]        ofs;
        logic [7:0]        abias;
        logic              snap_v;
        logic [MAP_AW-2:0] snap_tag;
        logic [7:0]        snap_lo;
    } reg_q_t;

endpackage

// File: rtl/bmon_pin_sync.sv
`timescale 1ns/1ps
module bmon_pin_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        if (STAGES > 1) begin : g_multi
            assign chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end else begin : g_single
            assign chain_d = raw_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign lvl_o[g] = chain_q[LAST];
    end
endmodule

// File: rtl/bmon_link.sv
`timescale 1ns/1ps
module bmon_link
    import bmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic [6:0]        dev_addr,
    input  logic [7:0]        rd_byte,
    output logic [MAP_AW:0]   ptr_o,
    output logic              rd_take,
    output logic              bus_evt,
    output logic              wr_en,
    output logic [MAP_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              sda_oe
);
    localparam link_q_t LINK_RST = '{
        st: L_IDLE, cnt: '0, sh: '0, ptr: '0, rw: 1'b0, nack: 1'b0,
        oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1, wr_en: 1'b0, wa: '0, wd: '0
    };

    link_q_t q, n;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [MAP_AW:0] ptr_inc;

    assign scl_rise = scl_lvl & ~q.scl_p;
    assign scl_fall = ~scl_lvl & q.scl_p;
    assign start_ev = scl_lvl & q.scl_p & q.sda_p & ~sda_lvl;
    assign stop_ev  = scl_lvl & q.scl_p & ~q.sda_p & sda_lvl;
    // pointer parks one past the top of the map
    assign ptr_inc  = q.ptr[MAP_AW] ? q.ptr : q.ptr + 1'b1;

    always_comb begin
        n        = q;
        n.scl_p  = scl_lvl;
        n.sda_p  = sda_lvl;
        n.wr_en  = 1'b0;
        rd_take  = 1'b0;

        if (start_ev) begin
            n.st  = L_DEV;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (stop_ev) begin
            n.st  = L_IDLE;
            n.oe  = 1'b0;
        end else begin
            case (q.st)
                L_DEV, L_PTR, L_WR: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[6:0], sda_lvl};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == L_DEV) begin
                            if (q.sh[7:1] == dev_addr) begin
                                n.st = L_DEV_ACK;
                                n.oe = 1'b1;
                                n.rw = q.sh[0];
                            end else begin
                                n.st = L_WAIT;
                            end
                        end else if (q.st == L_PTR) begin
                            n.ptr = {1'b0, q.sh};
                            n.oe  = 1'b1;
                            n.st  = L_PTR_ACK;
                        end else begin
                            n.wr_en = ~q.ptr[MAP_AW];
                            n.wa    = q.ptr[MAP_AW-1:0];
                            n.wd    = q.sh;
                            n.ptr   = ptr_inc;
                            n.oe    = 1'b1;
                            n.st    = L_WR_ACK;
                        end
                    end
                end
                L_DEV_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            rd_take = 1'b1;
                            n.sh    = rd_byte;
                            n.oe    = ~rd_byte[7];
                            n.cnt   = '0;
                            n.ptr   = ptr_inc;
                            n.st    = L_RD;
                        end else begin
                            n.oe  = 1'b0;
                            n.cnt = '0;
                            n.st  = L_PTR;
                        end
                    end
                end
                L_PTR_ACK, L_WR_ACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        n.st  = L_WR;
                    end
                end
                L_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.oe = 1'b0;
                            n.st = L_RD_ACK;
                        end else begin
                            n.cnt = q.cnt + 4'd1;
                            n.sh  = {q.sh[6:0], 1'b0};
                            n.oe  = ~q.sh[6];
                        end
                    end
                end
                L_RD_ACK: begin
                    if (scl_rise) begin
                        n.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            n.st = L_WAIT;
                        end else begin
                            rd_take = 1'b1;
                            n.sh    = rd_byte;
                            n.oe    = ~rd_byte[7];
                            n.cnt   = '0;
                            n.ptr   = ptr_inc;
                            n.st    = L_RD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= LINK_RST;
        else        q <= n;
    end

    assign ptr_o   = q.ptr;
    assign bus_evt = start_ev | stop_ev;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wa;
    assign wr_data = q.wd;
    assign sda_oe  = q.oe;
endmodule

// File: rtl/bmon_regfile.sv
`timescale 1ns/1ps
module bmon_regfile
    import bmon_pkg::*;
#(
    parameter logic [2:0] ADDR_LO_RST = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAP_AW:0]   ptr_i,
    input  logic              rd_take,
    input  logic              bus_evt,
    input  logic              wr_en,
    input  logic [MAP_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              gpio_lvl,
    input  logic [15:0]       temp_word,
    input  logic [15:0]       volt_word,
    input  logic [15:0]       curr_word,
    input  logic [15:0]       acc_word,
    output logic [7:0]        rd_byte,
    output logic              wr_stb,
    output logic [2:0]        addr_lo,
    output logic              sleep_en,
    output logic              neg_blank,
    output logic              gpio_oe,
    output logic [7:0]        ofs_bias,
    output logic [7:0]        acc_bias
);
    localparam reg_q_t REG_RST = '{
        por: 1'b1, sleep_en: 1'b0, nblank: 1'b0, pin_rel: 1'b0,
        alo: ADDR_LO_RST, ofs: '0, abias: '0,
        snap_v: 1'b0, snap_tag: '0, snap_lo: '0
    };

    reg_q_t q, n;
    logic       pair_ok, snap_use, in_map;
    logic [7:0] pair_hi, pair_lo;
    logic [MAP_AW-2:0] tag;

    assign in_map = ~ptr_i[MAP_AW];
    assign tag    = ptr_i[MAP_AW-1:1];

    always_comb begin
        pair_ok = 1'b1;
        case (tag)
            TAG_TEMP: {pair_hi, pair_lo} = temp_word;
            TAG_VOLT: {pair_hi, pair_lo} = volt_word;
            TAG_CURR: {pair_hi, pair_lo} = curr_word;
            TAG_ACC:  {pair_hi, pair_lo} = acc_word;
            default: begin
                pair_ok = 1'b0;
                {pair_hi, pair_lo} = 16'h0000;
            end
        endcase
    end

    assign snap_use = q.snap_v && (q.snap_tag == tag);

    always_comb begin
        if (!in_map) begin
            rd_byte = 8'hFF;
        end else if (pair_ok) begin
            rd_byte = ptr_i[0] ? (snap_use ? q.snap_lo : pair_lo) : pair_hi;
        end else begin
            case (ptr_i[MAP_AW-1:0])
                ADR_STAT:  rd_byte = {1'b1, q.por, q.sleep_en, q.nblank,
                                      gpio_lvl, q.alo};
                ADR_OFS:   rd_byte = q.ofs;
                ADR_ABIAS: rd_byte = q.abias;
                default:   rd_byte = 8'h00;
            endcase
        end
    end

    always_comb begin
        n = q;
        if (bus_evt) n.snap_v = 1'b0;
        if (rd_take && in_map && pair_ok && !ptr_i[0]) begin
            n.snap_v   = 1'b1;
            n.snap_tag = tag;
            n.snap_lo  = pair_lo;
        end
        if (wr_en) begin
            case (wr_addr)
                ADR_STAT: begin
                    n.por      = q.por & wr_data[6];
                    n.sleep_en = wr_data[5];
                    n.nblank   = wr_data[4];
                    n.pin_rel  = wr_data[3];
                    n.alo      = wr_data[2:0];
                end
                ADR_OFS:   n.ofs   = wr_data;
                ADR_ABIAS: n.abias = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REG_RST;
        else        q <= n;
    end

    assign wr_stb = wr_en && (wr_addr == ADR_STAT || wr_addr == ADR_ACC ||
                              wr_addr == ADR_ACC_L || wr_addr == ADR_OFS ||
                              wr_addr == ADR_ABIAS);
    assign addr_lo   = q.alo;
    assign sleep_en  = q.sleep_en;
    assign neg_blank = q.nblank;
    assign gpio_oe   = ~q.pin_rel;
    assign ofs_bias  = q.ofs;
    assign acc_bias  = q.abias;
endmodule

// File: rtl/bmon_i2c_slave.sv
`timescale 1ns/1ps
module bmon_i2c_slave
    import bmon_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ADDR_HI = 4'b1001,
    parameter logic [2:0] ADDR_LO_RST = 3'b000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        gpio_i,
    output logic        gpio_oe,
    input  logic [15:0] temp_word,
    input  logic [15:0] volt_word,
    input  logic [15:0] curr_word,
    input  logic [15:0] acc_word,
    output logic        wr_stb,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        cfg_sleep_en,
    output logic        cfg_neg_blank,
    output logic [7:0]  ofs_bias,
    output logic [7:0]  acc_bias
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] pin_lvl;
    logic [MAP_AW:0]    ptr;
    logic               rd_take, bus_evt, wr_en;
    logic [7:0]         rd_byte;
    logic [2:0]         addr_lo;

    bmon_pin_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({gpio_i, sda_i, scl_i}),
        .lvl_o (pin_lvl)
    );

    bmon_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (pin_lvl[0]),
        .sda_lvl  (pin_lvl[1]),
        .dev_addr ({DEV_ADDR_HI, addr_lo}),
        .rd_byte  (rd_byte),
        .ptr_o    (ptr),
        .rd_take  (rd_take),
        .bus_evt  (bus_evt),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    bmon_regfile #(.ADDR_LO_RST(ADDR_LO_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_i     (ptr),
        .rd_take   (rd_take),
        .bus_evt   (bus_evt),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .gpio_lvl  (pin_lvl[2]),
        .temp_word (temp_word),
        .volt_word (volt_word),
        .curr_word (curr_word),
        .acc_word  (acc_word),
        .rd_byte   (rd_byte),
        .wr_stb    (wr_stb),
        .addr_lo   (addr_lo),
        .sleep_en  (cfg_sleep_en),
        .neg_blank (cfg_neg_blank),
        .gpio_oe   (gpio_oe),
        .ofs_bias  (ofs_bias),
        .acc_bias  (acc_bias)
    );
endmodule

// File: rtl/bmon_i2c_slave_chk.sv
`timescale 1ns/1ps
module bmon_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       gpio_oe,
    input logic       cfg_sleep_en,
    input logic [7:0] ofs_bias
);
    // R12
    sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R11
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R11
    stb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr == 8'h01 || wr_addr == 8'h10 || wr_addr == 8'h11 ||
                    wr_addr == 8'h61 || wr_addr == 8'h62));

    // R10
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == 8'h01) |=> (gpio_oe == !$past(wr_data[3])));

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == 8'h01) |=> $stable(cfg_sleep_en));

    // R4
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_addr == 8'h61) |=> $stable(ofs_bias));
endmodule

bind bmon_i2c_slave bmon_i2c_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_oe       (sda_oe),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .gpio_oe      (gpio_oe),
    .cfg_sleep_en (cfg_sleep_en),
    .ofs_bias     (ofs_bias)
);

// File: tb/bmon_i2c_slave_test.sv
`timescale 1ns/1ps
module bmon_i2c_slave_test;
    localparam int Q  = 8;
    localparam int NV = 11;
    // {addr, write data, expected readback, strobe expected, requirement}
    localparam logic [31:0] VEC [NV] = '{
        {8'h61, 8'h5A, 8'h5A, 1'b1, 7'd4},   // R4 offset bias
        {8'h62, 8'hA5, 8'hA5, 1'b1, 7'd4},   // R4 accumulation bias
        {8'h0A, 8'h33, 8'h12, 1'b0, 7'd6},   // R6 read-only high
        {8'h0D, 8'h33, 8'h78, 1'b0, 7'd6},   // R6 read-only low
        {8'h30, 8'h77, 8'h00, 1'b0, 7'd6},   // R6 reserved
        {8'h01, 8'h78, 8'hF8, 1'b1, 7'd10},  // R10 flag write 1 keeps it
        {8'h01, 8'h38, 8'hB8, 1'b1, 7'd10},  // R10 flag cleared
        {8'h01, 8'h78, 8'hB8, 1'b1, 7'd10},  // R10 flag cannot be set
        {8'h01, 8'h30, 8'hB0, 1'b1, 7'd10},  // R10 pin driven low reads 0
        {8'h01, 8'h08, 8'h88, 1'b1, 7'd10},  // R10 pin released
        {8'h11, 8'h44, 8'hBC, 1'b1, 7'd11}   // R11 accumulator not stored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, gpio_oe, wr_stb, cfg_sleep_en, cfg_neg_blank;
    logic [7:0] wr_addr, wr_data, ofs_bias, acc_bias;
    logic [15:0] curr_word = 16'hABCD;
    logic sda_bus, gpio_pin;
    logic [6:0] dev = 7'h48;
    int n_chk = 0, n_fail = 0, stb_n = 0;
    logic [7:0] stb_a, stb_d;
    logic done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus  = m_sda & ~sda_oe;
    assign gpio_pin = ~gpio_oe;

    bmon_i2c_slave #(.SYNC_STAGES(3)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .gpio_i(gpio_pin), .gpio_oe(gpio_oe),
        .temp_word(16'h1234), .volt_word(16'h5678), .curr_word(curr_word),
        .acc_word(16'h9ABC), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_sleep_en(cfg_sleep_en), .cfg_neg_blank(cfg_neg_blank),
        .ofs_bias(ofs_bias), .acc_bias(acc_bias)
    );

    always @(posedge clk) begin
        if (rst_n && wr_stb) begin
            stb_n <= stb_n + 1;
            stb_a <= wr_addr;
            stb_d <= wr_data;
        end
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        logic k;
        bus_start(); put_byte({dev, 1'b0}, k); put_byte(a, k); put_byte(d, k); bus_stop();
    endtask

    task automatic rd_open(input logic [7:0] a);
        logic k;
        bus_start(); put_byte({dev, 1'b0}, k); put_byte(a, k);
        bus_start(); put_byte({dev, 1'b1}, k);
    endtask

    task automatic rd1(input logic [7:0] a, output logic [7:0] v);
        rd_open(a); get_byte(1'b0, v); bus_stop();
    endtask

    initial begin
        logic [7:0] v, v2, v3, v4;
        logic ack;
        int s0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "gpio_oe", gpio_oe, 1);
        chk("R1", "cfg bits", {cfg_sleep_en, cfg_neg_blank}, 0);
        chk("R1", "biases", {ofs_bias, acc_bias}, 0);
        rd1(8'h01, v);
        chk("R1", "status", v, 8'hC0);

        for (int i = 0; i < NV; i++) begin
            s0 = stb_n;
            wr1(VEC[i][31:24], VEC[i][23:16]);
            rd1(VEC[i][31:24], v);
            chk($sformatf("R%0d", VEC[i][6:0]), $sformatf("readback %0h", VEC[i][31:24]),
                v, VEC[i][15:8]);
            chk($sformatf("R%0d", VEC[i][6:0]), "strobe count", stb_n - s0, int'(VEC[i][7]));
        end
        chk("R11", "strobe addr/data", {stb_a, stb_d}, 16'h1144);
        chk("R10", "sleep bit after last write", cfg_sleep_en, 0);

        // R2 foreign address ignored
        bus_start(); put_byte({7'h4F, 1'b0}, ack);
        chk("R2", "foreign ack", ack, 0);
        put_byte(8'h61, ack); put_byte(8'h99, ack); bus_stop();
        chk("R2", "ofs after foreign", ofs_bias, 8'h5A);

        // R4 multi-byte write with increment
        bus_start(); put_byte({dev, 1'b0}, ack);
        chk("R2", "own ack", ack, 1);
        put_byte(8'h61, ack); put_byte(8'h11, ack);
        chk("R4", "data ack", ack, 1);
        put_byte(8'h22, ack); bus_stop();
        chk("R4", "biases", {ofs_bias, acc_bias}, 16'h1122);

        // R5 multi-byte read
        rd_open(8'h61); get_byte(1'b1, v); get_byte(1'b0, v2); bus_stop();
        chk("R5", "burst read", {v, v2}, 16'h1122);
        chk("R5", "released after nack", sda_oe, 0);
        rd_open(8'h0A); get_byte(1'b1, v); get_byte(1'b1, v2); get_byte(1'b1, v3);
        get_byte(1'b0, v4); bus_stop();
        chk("R5", "pair walk", {v, v2, v3, v4}, 32'h12345678);

        // R9 snapshot of low byte
        rd_open(8'h0E); get_byte(1'b1, v);
        curr_word = 16'h1357;
        get_byte(1'b0, v2); bus_stop();
        chk("R9", "latched pair", {v, v2}, 16'hABCD);
        rd1(8'h0F, v);
        chk("R9", "latch ended", v, 8'h57);

        // R7 past the top of the map
        rd_open(8'hFE); get_byte(1'b1, v); get_byte(1'b1, v2); get_byte(1'b1, v3);
        get_byte(1'b0, v4); bus_stop();
        chk("R7", "read past top", {v, v2, v3, v4}, 32'h0000FFFF);
        s0 = stb_n;
        bus_start(); put_byte({dev, 1'b0}, ack); put_byte(8'hFF, ack);
        put_byte(8'h00, ack); put_byte(8'h00, ack); put_byte(8'h00, ack); bus_stop();
        chk("R7", "no strobe past top", stb_n - s0, 0);
        rd1(8'h01, v);
        chk("R7", "status untouched", v, 8'h88);

        // R8 cut-short byte
        bus_start(); put_byte({dev, 1'b0}, ack); put_byte(8'h61, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk("R8", "partial byte", ofs_bias, 8'h11);

        // R3 programmable low address
        wr1(8'h01, 8'h0B);
        bus_start(); put_byte({7'h48, 1'b0}, ack); bus_stop();
        chk("R3", "old address", ack, 0);
        dev = 7'h4B;
        bus_start(); put_byte({dev, 1'b0}, ack); bus_stop();
        chk("R3", "new address", ack, 1);
        rd1(8'h01, v);
        chk("R3", "status via new address", v, 8'h8B);
        chk("R12", "sda idle", sda_oe, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(190000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule